// File: doc/BRIEF.md
# Staged System Reset Sequencer

This block turns four reset causes into a family of staged internal reset outputs. The causes are a power-on reset level, a reset pin level, a one-cycle software reset request and a one-cycle watchdog timeout request. The two levels are asynchronous. The two requests are strobes in the system-clock domain. Every output goes high at once, with no clock edge, when a source that qualifies for it goes high. The outputs then come out of reset one after another, each after its own count.

Three stages count on a slow relaxation-oscillator clock: the clock-generator reset, the peripheral reset and a stretched power-on reset. The core reset counts on the system clock, after the peripheral release has been synchronized into that domain. A debug-port reset follows the power-on level alone, through a two-flop synchronizer. A sticky cause register records which sources have fired since the last power-on. All outputs are active high.

Top module: `staged_reset_seq`

## Requirements
- R1: While `por_i` is high, all five reset outputs are 1 and `cause_o` reads 4'b0001.
- R2: A high `pin_rst_i` sets `clkgen_rst_o`, `perip_rst_o` and `core_rst_o` to 1 at once, with no clock edge, and they stay 1 while the pin is held.
- R3: `clkgen_rst_o` falls on the 34th rising edge of `rosc_clk_i` after the last source goes low. That is 2 synchronizer edges plus a count of 32.
- R4: `perip_rst_o` falls exactly 32 `rosc_clk_i` rising edges after `clkgen_rst_o` falls, and never before it.
- R5: `core_rst_o` falls on the 34th rising edge of `sys_clk_i` after `perip_rst_o` falls. That is 2 synchronizer edges plus a count of 32. It is never low while `perip_rst_o` is high.
- R6: `ext_por_o` is set only by `por_i` and falls on the 66th `rosc_clk_i` rising edge after `por_i` falls. It stays 0 for the pin, software and watchdog sources.
- R7: `dbg_rst_o` is set only by `por_i` and falls on the 2nd `rosc_clk_i` rising edge after `por_i` falls. It is therefore released before `ext_por_o`.
- R8: A software or watchdog request only one `sys_clk_i` cycle long is stretched across the clock boundary. Within 3 `rosc_clk_i` edges it sets `clkgen_rst_o`, `perip_rst_o` and `core_rst_o`, and a full release sequence follows.
- R9: If a source rises again during a release countdown, every counting stage clears. The whole sequence then restarts, timed from the last release.
- R10: `cause_o` has bit 0 for power-on, bit 1 for the pin, bit 2 for software and bit 3 for the watchdog. Bits are only ever added. `por_i` resets it to 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rosc_clk_i | input | 1 | Slow relaxation-oscillator clock |
| sys_clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on reset level, asynchronous, active high |
| pin_rst_i | input | 1 | External reset pin level, asynchronous, active high |
| sw_rst_req_i | input | 1 | Software reset strobe, sys_clk_i domain |
| wdog_rst_req_i | input | 1 | Watchdog timeout strobe, sys_clk_i domain |
| ext_por_o | output | 1 | Stretched power-on reset |
| clkgen_rst_o | output | 1 | Clock-generator reset |
| perip_rst_o | output | 1 | Peripheral reset |
| core_rst_o | output | 1 | Core reset |
| dbg_rst_o | output | 1 | Debug-port reset |
| cause_o | output | 4 | Sticky reset-cause bits |

## Verification
The hardest case to reach is a source that rises again in the middle of a cascade. At that moment the clock-generator stage has already released and the peripheral stage is still counting. The bench releases the pin just after a known oscillator edge and waits 40 edges, so the cascade is exactly in that window. It then pulses the pin again and checks that the release times are measured from the second release. Both clocks keep fixed phases that never coincide, so every fall time has one exact expected value. The sub-cycle strobes show that a request much shorter than an oscillator period is still caught.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Sticky record of which sources have fired since the last power-on.
    typedef struct packed {
        logic wdog;
        logic sw;
        logic pin;
        logic por;
    } cause_t;

    localparam int NUM_STROBES = 2;
    localparam int STB_SW      = 0;
    localparam int STB_WDOG    = 1;
    localparam int SYNC_DEPTH  = 2;

    // Width of a counter that reaches n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rstseq_stage.sv
// One release stage. Asserts asynchronously on hold_i. After hold_i drops,
// it flushes a SYNC_DEPTH flop chain, then counts DELAY edges while go_i is high.
module rstseq_stage #(
    parameter int DELAY = 32
) (
    input  logic clk_i,
    input  logic hold_i,
    input  logic go_i,
    output logic rst_o
);
    import rstseq_pkg::*;

    localparam int CW = cnt_width(DELAY);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [SYNC_DEPTH-1:0] sync_q;
    logic [CW-1:0]         cnt_q;

    always_ff @(posedge clk_i or posedge hold_i) begin
        if (hold_i) begin
            sync_q <= '1;
            cnt_q  <= '0;
            rst_o  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_DEPTH-2:0], 1'b0};
            if (sync_q[SYNC_DEPTH-1] || !go_i) begin
                cnt_q <= '0;
            end else if (rst_o) begin
                if (cnt_q == LAST) rst_o <= 1'b0;
                else               cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rstseq_strobe_cdc.sv
// Catches a system-clock strobe and holds it until the oscillator domain has
// seen it (request/acknowledge), giving at least SYNC_DEPTH oscillator cycles.
module rstseq_strobe_cdc (
    input  logic sys_clk_i,
    input  logic rosc_clk_i,
    input  logic clr_i,
    input  logic strobe_i,
    output logic held_o
);
    import rstseq_pkg::*;

    logic                  req_q;
    logic [SYNC_DEPTH-1:0] fwd_q;
    logic [SYNC_DEPTH-1:0] ack_q;

    always_ff @(posedge sys_clk_i or posedge clr_i) begin
        if (clr_i) begin
            req_q <= 1'b0;
            ack_q <= '0;
        end else begin
            ack_q <= {ack_q[SYNC_DEPTH-2:0], fwd_q[SYNC_DEPTH-1]};
            if (strobe_i)                 req_q <= 1'b1;
            else if (ack_q[SYNC_DEPTH-1]) req_q <= 1'b0;
        end
    end

    always_ff @(posedge rosc_clk_i or posedge clr_i) begin
        if (clr_i) fwd_q <= '0;
        else       fwd_q <= {fwd_q[SYNC_DEPTH-2:0], req_q};
    end

    assign held_o = fwd_q[SYNC_DEPTH-1];

endmodule

// File: rtl/rstseq_cause.sv
// Sticky cause log in the oscillator domain; power-on leaves only its own bit.
module rstseq_cause (
    input  logic                        rosc_clk_i,
    input  logic                        por_i,
    input  logic                        pin_i,
    input  logic [rstseq_pkg::NUM_STROBES-1:0] held_i,
    output rstseq_pkg::cause_t          cause_o
);
    import rstseq_pkg::*;

    logic [SYNC_DEPTH-1:0] pin_q;
    cause_t                hit;

    always_ff @(posedge rosc_clk_i or posedge por_i) begin
        if (por_i) pin_q <= '0;
        else       pin_q <= {pin_q[SYNC_DEPTH-2:0], pin_i};
    end

    always_comb begin
        hit      = '0;
        hit.pin  = pin_q[SYNC_DEPTH-1];
        hit.sw   = held_i[STB_SW];
        hit.wdog = held_i[STB_WDOG];
    end

    always_ff @(posedge rosc_clk_i or posedge por_i) begin
        if (por_i) cause_o <= '{wdog: 1'b0, sw: 1'b0, pin: 1'b0, por: 1'b1};
        else       cause_o <= cause_o | hit;
    end

endmodule

// File: rtl/staged_reset_seq.sv
module staged_reset_seq #(
    parameter int EXT_POR_DLY = 64,
    parameter int CLKGEN_DLY  = 32,
    parameter int PERIP_DLY   = 32,
    parameter int CORE_DLY    = 32
) (
    input  logic       rosc_clk_i,
    input  logic       sys_clk_i,
    input  logic       por_i,
    input  logic       pin_rst_i,
    input  logic       sw_rst_req_i,
    input  logic       wdog_rst_req_i,
    output logic       ext_por_o,
    output logic       clkgen_rst_o,
    output logic       perip_rst_o,
    output logic       core_rst_o,
    output logic       dbg_rst_o,
    output logic [3:0] cause_o
);
    import rstseq_pkg::*;

    logic [NUM_STROBES-1:0] strobes;
    logic [NUM_STROBES-1:0] held;
    logic                   any_src;
    logic [SYNC_DEPTH-1:0]  dbg_q;
    logic [SYNC_DEPTH-1:0]  perip_rel_q;
    cause_t                 cause;

    assign strobes[STB_SW]   = sw_rst_req_i;
    assign strobes[STB_WDOG] = wdog_rst_req_i;

    generate
        for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
            rstseq_strobe_cdc u_cdc (
                .sys_clk_i  (sys_clk_i),
                .rosc_clk_i (rosc_clk_i),
                .clr_i      (por_i),
                .strobe_i   (strobes[g]),
                .held_o     (held[g])
            );
        end
    endgenerate

    assign any_src = por_i | pin_rst_i | (|held);

    // Stretched power-on path: power-on only.
    rstseq_stage #(.DELAY(EXT_POR_DLY)) u_ext_por (
        .clk_i (rosc_clk_i), .hold_i (por_i), .go_i (1'b1), .rst_o (ext_por_o)
    );

    // Debug-port reset: power-on through a plain synchronizer.
    always_ff @(posedge rosc_clk_i or posedge por_i) begin
        if (por_i) dbg_q <= '1;
        else       dbg_q <= {dbg_q[SYNC_DEPTH-2:0], 1'b0};
    end
    assign dbg_rst_o = dbg_q[SYNC_DEPTH-1];

    // Cascade: clock generator, then peripherals, then core.
    rstseq_stage #(.DELAY(CLKGEN_DLY)) u_clkgen (
        .clk_i (rosc_clk_i), .hold_i (any_src), .go_i (1'b1), .rst_o (clkgen_rst_o)
    );

    rstseq_stage #(.DELAY(PERIP_DLY)) u_perip (
        .clk_i (rosc_clk_i), .hold_i (any_src), .go_i (!clkgen_rst_o), .rst_o (perip_rst_o)
    );

    // Peripheral release carried into the system-clock domain.
    always_ff @(posedge sys_clk_i or posedge any_src) begin
        if (any_src) perip_rel_q <= '0;
        else         perip_rel_q <= {perip_rel_q[SYNC_DEPTH-2:0], !perip_rst_o};
    end

    rstseq_stage #(.DELAY(CORE_DLY)) u_core (
        .clk_i (sys_clk_i), .hold_i (any_src), .go_i (perip_rel_q[SYNC_DEPTH-1]),
        .rst_o (core_rst_o)
    );

    rstseq_cause u_cause (
        .rosc_clk_i (rosc_clk_i),
        .por_i      (por_i),
        .pin_i      (pin_rst_i),
        .held_i     (held),
        .cause_o    (cause)
    );
    assign cause_o = cause;

endmodule

// File: rtl/staged_reset_seq_chk.sv
module staged_reset_seq_chk (
    input logic       rosc_clk_i,
    input logic       sys_clk_i,
    input logic       por_i,
    input logic       pin_rst_i,
    input logic       sw_rst_req_i,
    input logic       wdog_rst_req_i,
    input logic       ext_por_o,
    input logic       clkgen_rst_o,
    input logic       perip_rst_o,
    input logic       core_rst_o,
    input logic       dbg_rst_o,
    input logic [3:0] cause_o
);
    // R2
    pin_holds_rosc_chk: assert property (@(posedge rosc_clk_i) disable iff (por_i)
        pin_rst_i |-> (clkgen_rst_o && perip_rst_o));

    // R2
    pin_holds_core_chk: assert property (@(posedge sys_clk_i) disable iff (por_i)
        pin_rst_i |-> core_rst_o);

    // R3
    clkgen_release_chk: assert property (@(posedge rosc_clk_i) disable iff (por_i)
        $fell(clkgen_rst_o) |-> !pin_rst_i);

    // R4
    perip_order_chk: assert property (@(posedge rosc_clk_i) disable iff (por_i)
        !perip_rst_o |-> !clkgen_rst_o);

    // R5
    core_order_chk: assert property (@(posedge sys_clk_i) disable iff (por_i)
        !core_rst_o |-> !perip_rst_o);

    // R7
    dbg_before_ext_chk: assert property (@(posedge rosc_clk_i) disable iff (por_i)
        dbg_rst_o |-> ext_por_o);

    // R10
    cause_sticky_chk: assert property (@(posedge rosc_clk_i) disable iff (por_i)
        cause_o[0] |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

endmodule

bind staged_reset_seq staged_reset_seq_chk u_chk (.*);

// File: tb/tb_staged_reset_seq.sv
`timescale 1ns/100ps
module tb_staged_reset_seq;

    logic rosc_clk, sys_clk, por, pin, sw, wd;
    logic ext_por, clkgen, perip, core, dbg;
    logic [3:0] cause;

    int compared = 0;
    int mismatched = 0;
    realtime t_clk = 0, t_per = 0, t_core = 0, t_ext = 0, t_dbg = 0;

    staged_reset_seq dut (
        .rosc_clk_i (rosc_clk), .sys_clk_i (sys_clk), .por_i (por),
        .pin_rst_i (pin), .sw_rst_req_i (sw), .wdog_rst_req_i (wd),
        .ext_por_o (ext_por), .clkgen_rst_o (clkgen), .perip_rst_o (perip),
        .core_rst_o (core), .dbg_rst_o (dbg), .cause_o (cause)
    );

    // 200 MHz system clock, rising at 2.5 + 5k; oscillator 25 MHz, rising at 21 + 40k.
    initial begin sys_clk = 0; forever #2.5 sys_clk = ~sys_clk; end
    initial begin rosc_clk = 0; #1; forever #20 rosc_clk = ~rosc_clk; end

    always @(negedge clkgen)  t_clk  = $realtime;
    always @(negedge perip)   t_per  = $realtime;
    always @(negedge core)    t_core = $realtime;
    always @(negedge ext_por) t_ext  = $realtime;
    always @(negedge dbg)     t_dbg  = $realtime;

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_t(input string tag, input realtime act, input realtime exp);
        compared++;
        if (act < exp - 0.05 || act > exp + 0.05) begin
            mismatched++;
            $display("FAIL %s: actual %0.1f expected %0.1f", tag, act, exp);
        end
    endtask

    // Drops a level just after an oscillator edge; returns that edge's time.
    task automatic release_pin(output realtime te);
        @(posedge rosc_clk); te = $realtime; #5 pin = 0;
    endtask

    task automatic check_cascade(input string tag, input realtime te);
        check_t({tag, " R3 clkgen release"}, t_clk, te + 34 * 40);
        check_t({tag, " R4 perip release"}, t_per, te + 66 * 40);
        check_t({tag, " R5 core after perip"}, t_core - t_per, 166.5);
        check({tag, " R3 all released"}, {clkgen, perip, core}, 0);
    endtask

    task automatic test_por_sequence();
        realtime te;
        repeat (3) @(posedge rosc_clk); #5;
        check("R1 outputs in power-on", {ext_por, clkgen, perip, core, dbg}, 5'b11111);
        check("R1 cause in power-on", cause, 4'b0001);
        @(posedge rosc_clk); te = $realtime; #5 por = 0;
        repeat (75) @(posedge rosc_clk); #5;
        check_t("R7 dbg release", t_dbg, te + 2 * 40);
        check_t("R6 ext_por release", t_ext, te + 66 * 40);
        check_cascade("por", te);
        check("R6 ext_por low", ext_por, 0);
    endtask

    task automatic test_pin();
        realtime te;
        @(negedge rosc_clk); pin = 1; #1;
        check("R2 immediate assert", {clkgen, perip, core}, 3'b111);
        check("R6 R7 pin leaves por paths", {ext_por, dbg}, 2'b00);
        repeat (4) @(posedge rosc_clk);
        release_pin(te);
        repeat (75) @(posedge rosc_clk); #5;
        check_cascade("pin", te);
        check("R6 ext_por untouched by pin", ext_por, 0);
        check("R10 cause after pin", cause, 4'b0011);
    endtask

    task automatic test_strobe(input bit is_wd, input logic [3:0] exp_cause);
        realtime ts;
        @(negedge sys_clk); if (is_wd) wd = 1; else sw = 1; ts = $realtime;
        @(negedge sys_clk); wd = 0; sw = 0;
        repeat (3) @(posedge rosc_clk); #5;
        check("R8 strobe asserts resets", {clkgen, perip, core}, 3'b111);
        repeat (80) @(posedge rosc_clk); #5;
        check("R8 strobe sequence done", {clkgen, perip, core}, 0);
        check("R8 clkgen held long enough", int'(t_clk - ts > 32 * 40), 1);
        check("R6 R7 strobe leaves por paths", {ext_por, dbg}, 2'b00);
        check("R10 cause after strobe", cause, exp_cause);
    endtask

    task automatic test_restart();
        realtime te1, te2;
        @(negedge rosc_clk); pin = 1;
        repeat (3) @(posedge rosc_clk);
        release_pin(te1);
        repeat (40) @(posedge rosc_clk); #5;
        check("R9 mid countdown state", {clkgen, perip}, 2'b01);
        @(negedge rosc_clk); pin = 1; #1;
        check("R9 reassert clears release", {clkgen, perip, core}, 3'b111);
        repeat (3) @(posedge rosc_clk);
        release_pin(te2);
        repeat (75) @(posedge rosc_clk); #5;
        check_cascade("R9 restart", te2);
        check("R10 cause after restart", cause, 4'b1111);
    endtask

    task automatic test_por_again();
        @(negedge rosc_clk); por = 1; #1;
        check("R1 por reasserts all", {ext_por, clkgen, perip, core, dbg}, 5'b11111);
        check("R10 por clears cause", cause, 4'b0001);
        test_por_sequence();
    endtask

    initial begin
        repeat (150000) @(posedge sys_clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        por = 1; pin = 0; sw = 0; wd = 0;
        test_por_sequence();
        test_pin();
        test_strobe(1'b0, 4'b0111);
        test_strobe(1'b1, 4'b1111);
        test_restart();
        test_por_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule